// File: doc/BRIEF.md
# Motorised Door Controller

This block sequences a single motorised door from four inputs: a one-cycle open/close command, an obstruction sensor, a limit switch that reads high when the door is fully up, and a limit switch that reads high when the door is fully down. It drives two motor enables, one for raising and one for lowering.

The controller tracks whether the door is open, shut, rising, falling, or stopped part way. When it is stopped, it also tracks whether it stopped on the way up or on the way down. A command given while the door moves stops it, and the next command sends it the other way. An obstruction seen while the door is lowering sends it back up at once.

After reset the controller does not assume a door position. It reads the limit switches in its first active cycle and picks its starting state from them. Both motor enables are decoded from the state register alone, so they change only at a clock edge.

Top module: `door_opener_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the controller enters its settling state after that edge, and both motor outputs read 0 whatever the other inputs do.
- R2: At the first edge with `rst_n` high after reset, the controller picks its state from the limit switches. If `lim_top` is 1, it goes to open; `lim_top` wins when both switches read 1. Otherwise, if `lim_bottom` is 1, it goes to shut. If neither switch reads 1, it goes to stopped-going-down, and the next command raises the door.
- R3: In the open state, a command with `obstruct` at 0 starts lowering at the next edge. A command with `obstruct` at 1 is ignored, and both outputs stay 0.
- R4: While lowering, `obstruct` at 1 switches the door to raising at the next edge. This takes priority over a command and over `lim_bottom`.
- R5: While lowering, a command with no obstruction stops the door (both outputs 0). The next command raises it.
- R6: While lowering with no command and no obstruction, `lim_bottom` at 1 moves the door to shut, where it stays until a command starts raising.
- R7: While raising, a command stops the door (both outputs 0). This takes priority over `lim_top`. The next command lowers the door.
- R8: While raising with no command, `lim_top` at 1 moves the door to open, where it stays until a command arrives.
- R9: A stopped door holds its state, with both outputs 0, while no command arrives. The obstruction and limit inputs have no effect on it.
- R10: `motor_up` is 1 only in the raising state and `motor_down` is 1 only in the lowering state. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_toggle | input | 1 | Open/close command, one-cycle pulse |
| obstruct | input | 1 | Obstruction sensor, 1 = blocked |
| lim_top | input | 1 | Fully-up limit switch, 1 = reached |
| lim_bottom | input | 1 | Fully-down limit switch, 1 = reached |
| motor_up | output | 1 | Raise-motor enable |
| motor_down | output | 1 | Lower-motor enable |

## Verification
The inputs present at a rising edge choose the next state, and the motor outputs are decoded from that state. So every result is due exactly one edge after its stimulus, with no added latency. The driver applies each input vector at a falling edge and queues the outputs expected after the following rising edge. The monitor takes one item off the queue 1 ns after each rising edge and compares it against the outputs. Because the command is raised for one cycle only, each stop, reversal and resume is tied to the one edge where it must appear.

// File: rtl/door_ctrl_pkg.sv
// Package: shared state encoding for the door controller.
// Assumes: a single controller instance per door; state fits in STATE_W bits.
package door_ctrl_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_SETTLE   = 3'd0,  // post-reset, reads limit switches
        ST_OPEN     = 3'd1,  // fully up, idle
        ST_SHUT     = 3'd2,  // fully down, idle
        ST_RISING   = 3'd3,  // raise motor on
        ST_FALLING  = 3'd4,  // lower motor on
        ST_HOLD_UP  = 3'd5,  // stopped while rising
        ST_HOLD_DN  = 3'd6   // stopped while falling
    } door_state_t;

endpackage

// File: rtl/door_next_state.sv
// Module: door_next_state
// Purely combinational transition logic for the door controller.
// Assumes: inputs are already synchronised and debounced; cmd is a one-cycle pulse.
module door_next_state
    import door_ctrl_pkg::*;
(
    input  door_state_t cur_state,
    input  logic        cmd,
    input  logic        obst,
    input  logic        at_top,
    input  logic        at_bottom,
    output door_state_t nxt_state
);

    // Select the next state from the current state and the sensors.
    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_SETTLE: begin
                if (at_top)         nxt_state = ST_OPEN;
                else if (at_bottom) nxt_state = ST_SHUT;
                else                nxt_state = ST_HOLD_DN;
            end
            ST_OPEN: begin
                if (cmd && !obst)   nxt_state = ST_FALLING;
            end
            ST_FALLING: begin
                if (obst)           nxt_state = ST_RISING;
                else if (cmd)       nxt_state = ST_HOLD_DN;
                else if (at_bottom) nxt_state = ST_SHUT;
            end
            ST_RISING: begin
                if (cmd)            nxt_state = ST_HOLD_UP;
                else if (at_top)    nxt_state = ST_OPEN;
            end
            ST_SHUT: begin
                if (cmd)            nxt_state = ST_RISING;
            end
            ST_HOLD_UP: begin
                if (cmd)            nxt_state = ST_FALLING;
            end
            ST_HOLD_DN: begin
                if (cmd)            nxt_state = ST_RISING;
            end
            default:                nxt_state = ST_SETTLE;
        endcase
    end

endmodule

// File: rtl/door_state_reg.sv
// Module: door_state_reg
// Holds the controller state; synchronous active-low reset forces the settling state.
// Assumes: rst_n is synchronous to clk.
module door_state_reg
    import door_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  door_state_t nxt_state,
    output door_state_t cur_state
);

    // Register the next state, or the settling state while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_state <= ST_SETTLE;
        else        cur_state <= nxt_state;
    end

endmodule

// File: rtl/door_motor_decode.sv
// Module: door_motor_decode
// Decodes the motor enables from the state register alone (no input paths).
// Assumes: cur_state comes straight from a register, so outputs are glitch-free.
module door_motor_decode
    import door_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  door_state_t cur_state,
    output logic        up_en,
    output logic        down_en
);

    // Map the moving states onto their motor enables.
    always_comb begin
        up_en   = (cur_state == ST_RISING);
        down_en = (cur_state == ST_FALLING);
    end

    // R10
    motor_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_en && down_en));

endmodule

// File: rtl/door_opener_ctrl.sv
// Module: door_opener_ctrl (top)
// Door controller: stop-on-command while moving, reverse on the next command,
// reverse on obstruction while lowering, and derive the start state from the limit switches.
// Assumes: all inputs synchronous to clk and debounced; cmd_toggle is high for one cycle.
module door_opener_ctrl
    import door_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_toggle,
    input  logic obstruct,
    input  logic lim_top,
    input  logic lim_bottom,
    output logic motor_up,
    output logic motor_down
);

    door_state_t cur_state;
    door_state_t nxt_state;

    door_next_state u_next (
        .cur_state (cur_state),
        .cmd       (cmd_toggle),
        .obst      (obstruct),
        .at_top    (lim_top),
        .at_bottom (lim_bottom),
        .nxt_state (nxt_state)
    );

    door_state_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    door_motor_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_state (cur_state),
        .up_en     (motor_up),
        .down_en   (motor_down)
    );

    // Remember that the previous edge saw reset low, for the reset check.
    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // Check the state that follows a reset edge.
    always @(posedge clk) begin
        // R1
        if (rst_seen_q == 1'b1) begin
            settle_after_reset_chk: assert (cur_state == ST_SETTLE);
        end
    end

    // R2
    start_from_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_SETTLE && lim_top) |=> (cur_state == ST_OPEN));

    // R4
    reverse_on_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_FALLING && obstruct) |=> (cur_state == ST_RISING));

    // R7
    stop_while_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_RISING && cmd_toggle) |=> (cur_state == ST_HOLD_UP));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_state == ST_HOLD_UP || cur_state == ST_HOLD_DN) && !cmd_toggle)
        |=> $stable(cur_state));

endmodule

// File: tb/door_opener_ctrl_tb.sv
`timescale 1ns/100ps
module door_opener_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_toggle = 1'b0;
    logic obstruct = 1'b0;
    logic lim_top = 1'b0;
    logic lim_bottom = 1'b0;
    logic motor_up;
    logic motor_down;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  up;
        logic  down;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #2.5 clk = ~clk;

    door_opener_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_toggle (cmd_toggle),
        .obstruct   (obstruct),
        .lim_top    (lim_top),
        .lim_bottom (lim_bottom),
        .motor_up   (motor_up),
        .motor_down (motor_down)
    );

    // Driver: apply one vector at a falling edge and queue the outputs due after the next rise.
    task automatic drive(input logic r, input logic c, input logic o, input logic t,
                         input logic b, input logic eu, input logic ed, input string tag);
        exp_item_t it;
        @(negedge clk);
        rst_n = r; cmd_toggle = c; obstruct = o; lim_top = t; lim_bottom = b;
        it.up = eu; it.down = ed; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compare outputs shortly after every rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                checks++;
                if (motor_up !== it.up || motor_down !== it.down) begin
                    failures++;
                    $display("FAIL %s: up/down=%b%b expected %b%b", it.tag,
                             motor_up, motor_down, it.up, it.down);
                end
                checks++;
                if (motor_up === 1'b1 && motor_down === 1'b1) begin
                    failures++;
                    $display("FAIL R10: up/down=%b%b expected not 11", motor_up, motor_down);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog: run incomplete, expected completion");
        finish_run();
    end

    // Stimulus sequence.
    initial begin
        // R1: reset, with other inputs active
        drive(0,0,0,0,0, 0,0,"R1");
        drive(0,1,0,1,0, 0,0,"R1");
        // R2: start from bottom switch -> shut
        drive(1,0,0,0,1, 0,0,"R2");
        drive(1,1,0,0,1, 1,0,"R2");
        // R8: rising until top switch
        drive(1,0,0,0,0, 1,0,"R8");
        drive(1,0,0,1,0, 0,0,"R8");
        drive(1,0,0,1,0, 0,0,"R8");
        // R3: command under obstruction ignored, then a clean one lowers
        drive(1,1,1,1,0, 0,0,"R3");
        drive(1,0,0,1,0, 0,0,"R3");
        drive(1,1,0,1,0, 0,1,"R3");
        // R6: falling until bottom switch, stay shut, command raises
        drive(1,0,0,0,0, 0,1,"R6");
        drive(1,0,0,0,1, 0,0,"R6");
        drive(1,0,0,0,1, 0,0,"R6");
        drive(1,1,0,0,1, 1,0,"R6");
        // R7: command beats top switch while rising
        drive(1,1,0,1,0, 0,0,"R7");
        // R9: stopped-up ignores obstruction and limits
        drive(1,0,1,1,0, 0,0,"R9");
        drive(1,0,1,1,1, 0,0,"R9");
        // R7: next command lowers
        drive(1,1,0,0,0, 0,1,"R7");
        // R5: command while falling stops; stopped-down holds; next command raises
        drive(1,1,0,0,0, 0,0,"R5");
        drive(1,0,1,0,1, 0,0,"R9");
        drive(1,1,0,0,0, 1,0,"R5");
        drive(1,0,0,1,0, 0,0,"R8");
        drive(1,1,0,0,0, 0,1,"R3");
        // R4: obstruction beats command and bottom switch
        drive(1,1,1,0,1, 1,0,"R4");
        drive(1,0,0,1,0, 0,0,"R4");
        // R1: reset in motion
        drive(1,1,0,0,0, 0,1,"R3");
        drive(0,0,0,0,0, 0,0,"R1");
        // R2: both switches -> open wins
        drive(1,0,0,1,1, 0,0,"R2");
        drive(1,1,0,0,0, 0,1,"R2");
        // R2: no switch -> stopped-down, command raises
        drive(0,0,0,0,0, 0,0,"R1");
        drive(1,0,0,0,0, 0,0,"R2");
        drive(1,0,0,0,0, 0,0,"R9");
        drive(1,1,0,0,0, 1,0,"R2");
        drive(1,0,0,0,0, 1,0,"R10");
        @(negedge clk);
        cmd_toggle = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule